// File: doc/BRIEF.md
# Accumulator ALU with Condition Flags

This block does the 8-bit arithmetic and logic work for a small accumulator machine. Each time `issue` is asserted it takes the current accumulator value, the incoming carry and a second operand, and performs one of six operations: add, add with carry, subtract, subtract with borrow, compare or inclusive OR. It registers the new accumulator value together with six condition flags. The second operand comes from one of three places: a byte picked out of a register bank by a 3-bit index, an immediate byte, or a byte read from memory.

Compare works out its flags as a subtraction would, but the accumulator keeps its old value. The add/subtract flag records which kind of operation ran. The block also reports the machine-cycle count and the clock-state count that belong to the operand source used. All results appear on the clock edge that follows the issue, and `out_valid` is high for that one cycle.

Top module: `accalu`

## Requirements
- R1: Opcode 0 (add) and opcode 1 (add with carry) give `acc_out` = (`acc_in` + operand + c) mod 256, where c is `carry_in` for opcode 1 and 0 for opcode 0. The result is registered on the edge after `issue`, and `out_valid` is high for exactly that cycle.
- R2: Opcode 2 (subtract) and opcode 3 (subtract with borrow) give `acc_out` = (`acc_in` − operand − c) mod 256, where c is `carry_in` for opcode 3 and 0 for opcode 2.
- R3: Opcode 7 (compare) sets every flag exactly as opcode 2 would for the same inputs, and `acc_out` equals `acc_in`.
- R4: `src_sel` chooses the operand. 0 takes byte `reg_idx` of `reg_bank`, which is bits [8·idx+7 : 8·idx]. 1 takes `imm_byte`. 2 (memory through pointer) and 3 (memory through index plus displacement) both take `mem_byte`.
- R5: `flags_out` is laid out as bit5 S, bit4 Z, bit3 H, bit2 P/V, bit1 N, bit0 C. S is bit 7 of the 8-bit result, and Z is 1 when that result is zero. For compare the result is the difference, not `acc_out`.
- R6: For arithmetic opcodes, H is the carry out of bit 3 (for add) or the borrow into bit 4 (for subtract). C is the carry or borrow out of bit 7.
- R7: For arithmetic opcodes, P/V is 1 on two's-complement signed overflow. For OR it is 1 when the result has an even number of one bits.
- R8: N is 1 after opcodes 2, 3 and 7, and 0 after opcodes 0, 1 and 6.
- R9: Opcode 6 (OR) gives `acc_out` = `acc_in` | operand and clears H, N and C.
- R10: `mcyc_out`/`tstate_out` are 1/4 for `src_sel` 0, 2/7 for `src_sel` 1 and 2, and 4/15 for `src_sel` 3.
- R11: Opcodes 4 and 5 are reserved. An issue that carries one of them leaves `out_valid` low and holds `acc_out`, `flags_out`, `mcyc_out` and `tstate_out` at their previous values.
- R12: Synchronous active-high `rst` drives every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | Start one operation this cycle |
| op_code | input | 3 | Operation select |
| src_sel | input | 2 | Operand source select |
| reg_idx | input | 3 | Register bank index for the register source |
| reg_bank | input | 64 | Eight 8-bit registers, register i in bits [8i+7:8i] |
| imm_byte | input | 8 | Immediate operand |
| mem_byte | input | 8 | Byte read from memory |
| acc_in | input | 8 | Current accumulator |
| carry_in | input | 1 | Current carry flag |
| out_valid | output | 1 | Result registered this cycle |
| acc_out | output | 8 | New accumulator value |
| flags_out | output | 6 | {S, Z, H, P/V, N, C} |
| mcyc_out | output | 3 | Machine cycles of the issued form |
| tstate_out | output | 4 | Clock states of the issued form |

## Verification
The assertions read the previous cycle's `op_code`, `src_sel` and `acc_in` through `$past`, and they rely on those inputs being valid in any cycle where `issue` is high. They also require `issue` to be low while `rst` is asserted. The bench meets both conditions: it changes inputs only on the falling edge, drives `issue` only after reset has been released, and keeps every operand field defined the whole time. Random operations use only the six defined opcodes. The reserved codes are applied in directed steps, where the held outputs are compared against the values from the previous operation.

// File: rtl/accalu_pkg.sv
package accalu_pkg;

    localparam int DW     = 8;
    localparam int NIB    = 4;
    localparam int MCYC_W = 3;
    localparam int TST_W  = 4;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_ADC = 3'd1,
        OP_SUB = 3'd2,
        OP_SBC = 3'd3,
        OP_OR  = 3'd6,
        OP_CP  = 3'd7
    } alu_op_e;

    typedef enum logic [1:0] {
        SRC_REG = 2'd0,
        SRC_IMM = 2'd1,
        SRC_PTR = 2'd2,
        SRC_IDX = 2'd3
    } src_e;

    typedef struct packed {
        logic s;
        logic z;
        logic h;
        logic pv;
        logic n;
        logic c;
    } flags_t;

    typedef struct packed {
        logic [MCYC_W-1:0] mcyc;
        logic [TST_W-1:0]  tst;
    } timing_t;

    typedef struct packed {
        logic [DW-1:0] acc;
        flags_t        fl;
    } alu_res_t;

    function automatic logic even_parity(input logic [DW-1:0] v);
        return ~(^v);
    endfunction

    function automatic logic op_known(input logic [2:0] code);
        return !(code == 3'd4 || code == 3'd5);
    endfunction

    function automatic timing_t src_timing(input src_e s);
        timing_t t;
        case (s)
            SRC_REG: t = '{mcyc: MCYC_W'(1), tst: TST_W'(4)};
            SRC_IMM,
            SRC_PTR: t = '{mcyc: MCYC_W'(2), tst: TST_W'(7)};
            default: t = '{mcyc: MCYC_W'(4), tst: TST_W'(15)};
        endcase
        return t;
    endfunction

endpackage

// File: rtl/accalu_opnd.sv
module accalu_opnd
    import accalu_pkg::*;
#(
    parameter int NREG  = 8,
    localparam int IDX_W = $clog2(NREG)
) (
    input  src_e                 src,
    input  logic [IDX_W-1:0]     idx,
    input  logic [NREG*DW-1:0]   bank_flat,
    input  logic [DW-1:0]        imm,
    input  logic [DW-1:0]        mem,
    output logic [DW-1:0]        operand
);

    logic [DW-1:0] bank [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_unpack
        assign bank[g] = bank_flat[g*DW +: DW];
    end

    always_comb begin
        case (src)
            SRC_REG: operand = bank[idx];
            SRC_IMM: operand = imm;
            default: operand = mem;
        endcase
    end

endmodule

// File: rtl/accalu_core.sv
module accalu_core
    import accalu_pkg::*;
(
    input  alu_op_e        op,
    input  logic [DW-1:0]  a,
    input  logic [DW-1:0]  b,
    input  logic           cin,
    output alu_res_t       res
);

    logic          is_sub;
    logic          ci;
    logic          cadd;
    logic [DW-1:0] b_eff;
    logic [DW:0]   wide;
    logic [NIB:0]  nib;
    logic [DW-1:0] r;

    always_comb begin
        is_sub = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CP);
        ci     = ((op == OP_ADC) || (op == OP_SBC)) && cin;
        b_eff  = is_sub ? ~b : b;
        cadd   = is_sub ? ~ci : ci;
        wide   = {1'b0, a} + {1'b0, b_eff} + {{DW{1'b0}}, cadd};
        nib    = {1'b0, a[NIB-1:0]} + {1'b0, b_eff[NIB-1:0]} + {{NIB{1'b0}}, cadd};

        if (op == OP_OR) begin
            r        = a | b;
            res.fl.h = 1'b0;
            res.fl.n = 1'b0;
            res.fl.c = 1'b0;
            res.fl.pv = even_parity(r);
        end else begin
            r         = wide[DW-1:0];
            res.fl.h  = nib[NIB] ^ is_sub;
            res.fl.n  = is_sub;
            res.fl.c  = wide[DW] ^ is_sub;
            res.fl.pv = (a[DW-1] == b_eff[DW-1]) && (r[DW-1] != a[DW-1]);
        end
        res.fl.s = r[DW-1];
        res.fl.z = (r == '0);
        res.acc  = (op == OP_CP) ? a : r;
    end

endmodule

// File: rtl/accalu.sv
module accalu
    import accalu_pkg::*;
#(
    parameter int NREG  = 8,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                issue,
    input  logic [2:0]          op_code,
    input  logic [1:0]          src_sel,
    input  logic [IDX_W-1:0]    reg_idx,
    input  logic [NREG*DW-1:0]  reg_bank,
    input  logic [DW-1:0]       imm_byte,
    input  logic [DW-1:0]       mem_byte,
    input  logic [DW-1:0]       acc_in,
    input  logic                carry_in,
    output logic                out_valid,
    output logic [DW-1:0]       acc_out,
    output logic [5:0]          flags_out,
    output logic [MCYC_W-1:0]   mcyc_out,
    output logic [TST_W-1:0]    tstate_out
);

    logic [DW-1:0] operand;
    alu_res_t      res_c;
    alu_res_t      res_q;
    timing_t       tim_q;
    logic          accept;

    accalu_opnd #(.NREG(NREG)) u_opnd (
        .src       (src_e'(src_sel)),
        .idx       (reg_idx),
        .bank_flat (reg_bank),
        .imm       (imm_byte),
        .mem       (mem_byte),
        .operand   (operand)
    );

    accalu_core u_core (
        .op  (alu_op_e'(op_code)),
        .a   (acc_in),
        .b   (operand),
        .cin (carry_in),
        .res (res_c)
    );

    assign accept = issue && op_known(op_code);

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q     <= '0;
            tim_q     <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= accept;
            if (accept) begin
                res_q <= res_c;
                tim_q <= src_timing(src_e'(src_sel));
            end
        end
    end

    assign acc_out    = res_q.acc;
    assign flags_out  = res_q.fl;
    assign mcyc_out   = tim_q.mcyc;
    assign tstate_out = tim_q.tst;

endmodule

// File: rtl/accalu_chk.sv
module accalu_chk
    import accalu_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              issue,
    input logic [2:0]        op_code,
    input logic [1:0]        src_sel,
    input logic [DW-1:0]     acc_in,
    input logic              out_valid,
    input logic [DW-1:0]     acc_out,
    input logic [5:0]        flags_out,
    input logic [MCYC_W-1:0] mcyc_out,
    input logic [TST_W-1:0]  tstate_out
);

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        out_valid == $past(issue && op_known(op_code)));                                      // R1
    AST_N_RULE: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> flags_out[1] == ($past(op_code) inside {3'd2, 3'd3, 3'd7}));             // R8
    AST_OR_CLEARS: assert property (@(posedge clk) disable iff (rst)
        out_valid && $past(op_code) == 3'd6 |-> flags_out[3] == 1'b0 && flags_out[0] == 1'b0); // R9
    AST_CP_HOLDS: assert property (@(posedge clk) disable iff (rst)
        out_valid && $past(op_code) == 3'd7 |-> acc_out == $past(acc_in));                     // R3
    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
        out_valid && $past(op_code) != 3'd7 |-> flags_out[4] == (acc_out == '0));              // R5
    AST_SIGN_FLAG: assert property (@(posedge clk) disable iff (rst)
        out_valid && $past(op_code) != 3'd7 |-> flags_out[5] == acc_out[DW-1]);                // R5
    AST_REG_TIMING: assert property (@(posedge clk) disable iff (rst)
        out_valid && $past(src_sel) == 2'd0 |-> mcyc_out == 3'd1 && tstate_out == 4'd4);       // R10
    AST_IDX_TIMING: assert property (@(posedge clk) disable iff (rst)
        out_valid && $past(src_sel) == 2'd3 |-> mcyc_out == 3'd4 && tstate_out == 4'd15);      // R10
    AST_RESERVED_HOLD: assert property (@(posedge clk) disable iff (rst)
        issue && !op_known(op_code) |=> !out_valid && $stable(acc_out) && $stable(flags_out)); // R11

endmodule

bind accalu accalu_chk u_chk (.*);

// File: tb/accalu_bench.sv
module accalu_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        issue;
    logic [2:0]  op_code;
    logic [1:0]  src_sel;
    logic [2:0]  reg_idx;
    logic [63:0] reg_bank;
    logic [7:0]  imm_byte;
    logic [7:0]  mem_byte;
    logic [7:0]  acc_in;
    logic        carry_in;
    logic        out_valid;
    logic [7:0]  acc_out;
    logic [5:0]  flags_out;
    logic [2:0]  mcyc_out;
    logic [3:0]  tstate_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    accalu u_accalu (
        .clk(clk), .rst(rst), .issue(issue), .op_code(op_code), .src_sel(src_sel),
        .reg_idx(reg_idx), .reg_bank(reg_bank), .imm_byte(imm_byte), .mem_byte(mem_byte),
        .acc_in(acc_in), .carry_in(carry_in), .out_valid(out_valid), .acc_out(acc_out),
        .flags_out(flags_out), .mcyc_out(mcyc_out), .tstate_out(tstate_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int sgn(input int v);
        return (v > 127) ? v - 256 : v;
    endfunction

    // returns {acc[7:0], S, Z, H, PV, N, C}
    function automatic logic [13:0] model(input int op, input int a, input int b, input int cy);
        int ci, s, r, sv;
        bit h, v, c, n;
        if (op == 6) begin
            r = a | b; h = 0; c = 0; n = 0;
            v = (($countones(r[7:0]) % 2) == 0);
        end else if (op <= 1) begin
            ci = (op == 1) ? cy : 0;
            s  = a + b + ci;       r = s & 255;
            c  = s > 255;
            h  = ((a & 15) + (b & 15) + ci) > 15;
            sv = sgn(a) + sgn(b) + ci;
            v  = (sv > 127) || (sv < -128);
            n  = 0;
        end else begin
            ci = (op == 3) ? cy : 0;
            s  = a - b - ci;       r = s & 255;
            c  = s < 0;
            h  = ((a & 15) - (b & 15) - ci) < 0;
            sv = sgn(a) - sgn(b) - ci;
            v  = (sv > 127) || (sv < -128);
            n  = 1;
        end
        return {(op == 7) ? 8'(a) : 8'(r), r[7], (r & 255) == 0, h, v, n, c};
    endfunction

    task automatic run_op(input int op, input int src, input int idx, input int imm,
                          input int mem, input int a, input int cy);
        int b;
        logic [13:0] e;
        string rq;
        issue = 1; op_code = 3'(op); src_sel = 2'(src); reg_idx = 3'(idx);
        imm_byte = 8'(imm); mem_byte = 8'(mem); acc_in = 8'(a); carry_in = 1'(cy);
        b = (src == 0) ? int'(reg_bank[idx*8 +: 8]) : (src == 1) ? imm : mem;
        e = model(op, a, b, cy);
        @(negedge clk);
        issue = 0;
        rq = (op <= 1) ? "R1" : (op == 6) ? "R9" : (op == 7) ? "R3" : "R2";
        chk("R1 valid", int'(out_valid), 1);
        chk({rq, " acc R4"}, int'(acc_out), int'(e[13:6]));
        chk("R5 S", int'(flags_out[5]), int'(e[5]));
        chk("R5 Z", int'(flags_out[4]), int'(e[4]));
        chk("R6 H", int'(flags_out[3]), int'(e[3]));
        chk("R7 PV", int'(flags_out[2]), int'(e[2]));
        chk("R8 N", int'(flags_out[1]), int'(e[1]));
        chk("R6 C", int'(flags_out[0]), int'(e[0]));
        chk("R10 mcyc", int'(mcyc_out), (src == 0) ? 1 : (src == 3) ? 4 : 2);
        chk("R10 tst", int'(tstate_out), (src == 0) ? 4 : (src == 3) ? 15 : 7);
    endtask

    task automatic run_reserved(input int op);
        logic [7:0] a0; logic [5:0] f0; logic [2:0] m0; logic [3:0] t0;
        a0 = acc_out; f0 = flags_out; m0 = mcyc_out; t0 = tstate_out;
        issue = 1; op_code = 3'(op); src_sel = 2'd3; acc_in = 8'h5A; imm_byte = 8'hFF; mem_byte = 8'h0F;
        @(negedge clk);
        issue = 0;
        chk("R11 valid", int'(out_valid), 0);
        chk("R11 acc", int'(acc_out), int'(a0));
        chk("R11 flags", int'(flags_out), int'(f0));
        chk("R11 timing", int'({mcyc_out, tstate_out}), int'({m0, t0}));
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int ops[6] = '{0, 1, 2, 3, 6, 7};
        void'($urandom(32'd1234));
        rst = 1; issue = 0; op_code = 0; src_sel = 0; reg_idx = 0;
        reg_bank = 64'h0706_0504_0302_0100; imm_byte = 0; mem_byte = 0; acc_in = 0; carry_in = 0;
        repeat (3) @(negedge clk);
        chk("R12 valid", int'(out_valid), 0);
        chk("R12 acc", int'(acc_out), 0);
        chk("R12 flags", int'(flags_out), 0);
        chk("R12 timing", int'({mcyc_out, tstate_out}), 0);
        rst = 0;
        @(negedge clk);

        // directed corners
        run_op(0, 1, 0, 8'h01, 0, 8'h7F, 0);     // R7 overflow on add, R6 half carry
        run_op(2, 2, 0, 0, 8'h01, 8'h80, 0);     // R2 overflow on subtract
        run_op(3, 3, 0, 0, 8'h00, 8'h00, 1);     // R2 borrow in gives FF
        run_op(1, 1, 0, 8'h00, 0, 8'hFF, 1);     // R1 carry in wraps to zero
        run_op(7, 1, 0, 8'h42, 0, 8'h42, 1);     // R3 equal compare
        run_op(7, 0, 5, 0, 0, 8'h01, 0);         // R3 compare with borrow, reg source R4
        run_op(6, 1, 0, 8'h00, 0, 8'h03, 1);     // R9 parity even
        run_op(6, 2, 0, 0, 8'h01, 8'h00, 1);     // R9 parity odd
        run_reserved(4);                          // R11
        run_reserved(5);                          // R11
        run_op(0, 0, 7, 0, 0, 8'h10, 0);          // R4 top register

        for (int i = 0; i < 400; i++) begin
            reg_bank = {$urandom, $urandom};
            run_op(ops[$urandom % 6], $urandom % 4, $urandom % 8, $urandom % 256,
                   $urandom % 256, $urandom % 256, $urandom % 2);
        end

        rst = 1;
        @(negedge clk);
        rst = 0;
        chk("R12 acc after rst", int'(acc_out), 0);
        chk("R12 flags after rst", int'(flags_out), 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule